// File: doc/BRIEF.md
# Serial ADC Slave Responder

This block stands in for the serial port of an eight-channel, 12-bit sampling converter so that an SPI master design can be exercised without real silicon. It runs on a fast system clock and treats chip-select, serial clock and data-in as asynchronous inputs. It resynchronises them and finds their edges inside the system clock domain.

Every frame is sixteen serial clocks long. During the frame the master shifts a three-bit channel number in on the data-in line, and the responder shifts a 12-bit sample out on the data-out line. Samples are taken from eight parallel input words. The channel named in one frame is the one whose word is returned in the frame that follows. For checking, the block raises a one-cycle completion pulse and presents the channel number it latched.

Top module: `adc_serial_responder`

## Requirements
- R1: After reset, dout is 0, frameDone is 0 and capturedAddr is 0.
- R2: The channel address is taken from din at serial-clock rising edges 2, 3 and 4 of a frame (edges counted from 0), most significant bit first. The din value at edges 0, 1 and 5 to 15 has no effect on the address.
- R3: dout is 0 during bit positions 0 to 3 of a frame.
- R4: During positions 4 to 15, dout carries the selected 12-bit sample, bit 11 first and bit 0 last. Position 0 is driven from the falling edge of chip-select, and each later position is driven from the serial-clock falling edge that follows the previous rising edge.
- R5: A frame returns the sample of the channel latched by the previous completed frame. The first frame after reset returns channel 0. Channel k is bits [12k+11:12k] of chanData.
- R6: After the 16th rising edge of a frame, frameDone is high for exactly one system cycle. From that cycle on, capturedAddr shows the address of that frame.
- R7: If chip-select rises before the 16th rising edge, no frameDone is given, and the latched address stays unchanged.
- R8: dout is 0 while chip-select is high.
- R9: Serial-clock edges that occur while chip-select is high have no effect. They give no frameDone and do not change the address.
- R10: The sample is latched when the frame starts. Changes to chanData later in that frame do not alter the bits being shifted out.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the serial clock |
| rstN | input | 1 | Asynchronous active-low reset |
| csN | input | 1 | Chip-select from the master, active low |
| sclk | input | 1 | Serial clock from the master, idles high |
| din | input | 1 | Serial data from the master |
| chanData | input | 96 | Eight 12-bit sample words, with channel 0 in the low bits |
| dout | output | 1 | Serial sample data to the master |
| frameDone | output | 1 | One-cycle pulse when a full frame completes |
| capturedAddr | output | 3 | Channel address latched by the last completed frame |

## Verification
The assertions assume a well-formed master. The serial clock is slow next to the system clock, so each serial-clock level lasts several system cycles. Chip-select does not fall again until it has been seen high after the previous frame. The bench respects both assumptions. It holds every serial-clock phase for eight system cycles, and it changes din only together with a serial-clock falling edge, so din is stable through the synchroniser before each rising edge. Chip-select changes only while the serial clock is high and has settled.

// File: rtl/adc_resp_pkg.sv
package adc_resp_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SHIFT,
    ST_HOLD
  } frameState_t;

  // Strobes from the control block to the datapath, valid for one cycle.
  typedef struct packed {
    logic frameStart;  // latch the sample of the pending channel
    logic addrBit;     // shift the synchronised din into the address
    logic shiftOut;    // advance dout to the next position
    logic commit;      // frame complete: publish the address
    logic clearOut;    // chip-select went high: blank dout
  } ctrlStrobes_t;

endpackage

// File: rtl/adc_resp_sync.sv
module adc_resp_sync #(
  parameter int WIDTH = 3,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] IDLE_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] rawIn,
  output logic [WIDTH-1:0] syncOut
);

  logic [WIDTH-1:0] pipe [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) pipe[0] <= IDLE_VAL;
          else       pipe[0] <= rawIn;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) pipe[s] <= IDLE_VAL;
          else       pipe[s] <= pipe[s-1];
        end
      end
    end
  endgenerate

  assign syncOut = pipe[STAGES-1];

endmodule

// File: rtl/adc_resp_ctrl.sv
module adc_resp_ctrl
  import adc_resp_pkg::*;
#(
  parameter int FRAME_LEN = 16,
  parameter int ADDR_POS = 2,
  parameter int ADDR_W = 3
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         csQ,
  input  logic         sclkQ,
  output logic         csPrev,
  output ctrlStrobes_t strobes
);

  localparam int CNT_W = $clog2(FRAME_LEN);
  localparam logic [CNT_W-1:0] LAST_POS = CNT_W'(FRAME_LEN - 1);
  localparam logic [CNT_W-1:0] ADDR_FIRST = CNT_W'(ADDR_POS);
  localparam logic [CNT_W-1:0] ADDR_LAST = CNT_W'(ADDR_POS + ADDR_W - 1);

  frameState_t state, stateNext;
  logic [CNT_W-1:0] bitCnt, bitCntNext;
  logic sclkPrev;
  logic csFall, csRise, sclkRise, sclkFall;

  assign csFall   = csPrev & ~csQ;
  assign csRise   = ~csPrev & csQ;
  assign sclkRise = ~sclkPrev & sclkQ;
  assign sclkFall = sclkPrev & ~sclkQ;

  always_comb begin
    stateNext  = state;
    bitCntNext = bitCnt;
    strobes    = '0;
    strobes.clearOut = csRise;
    if (csFall) begin
      strobes.frameStart = 1'b1;
      stateNext  = ST_SHIFT;
      bitCntNext = '0;
    end else begin
      case (state)
        ST_SHIFT: begin
          if (csRise) begin
            stateNext = ST_IDLE;  // partial frame dropped
          end else if (sclkRise) begin
            strobes.addrBit = (bitCnt >= ADDR_FIRST) && (bitCnt <= ADDR_LAST);
            if (bitCnt == LAST_POS) begin
              strobes.commit = 1'b1;
              stateNext = ST_HOLD;
            end else begin
              bitCntNext = bitCnt + 1'b1;
            end
          end else if (sclkFall && (bitCnt != '0)) begin
            strobes.shiftOut = 1'b1;
          end
        end
        ST_HOLD: begin
          if (csRise) stateNext = ST_IDLE;
        end
        default: stateNext = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      bitCnt   <= '0;
      csPrev   <= 1'b1;
      sclkPrev <= 1'b1;
    end else begin
      state    <= stateNext;
      bitCnt   <= bitCntNext;
      csPrev   <= csQ;
      sclkPrev <= sclkQ;
    end
  end

endmodule

// File: rtl/adc_resp_datapath.sv
module adc_resp_datapath
  import adc_resp_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int SAMPLE_W = 12,
  parameter int DATA_POS = 4,
  parameter int ADDR_W = 3
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  ctrlStrobes_t               strobes,
  input  logic                       dinQ,
  input  logic [NUM_CH*SAMPLE_W-1:0] chanData,
  output logic                       dout,
  output logic                       frameDone,
  output logic [ADDR_W-1:0]          capturedAddr
);

  localparam int SHIFT_W = DATA_POS + SAMPLE_W;

  logic [SHIFT_W-1:0]  shiftReg;
  logic [ADDR_W-1:0]   addrShift;
  logic [SAMPLE_W-1:0] selSample;

  assign selSample = chanData[capturedAddr*SAMPLE_W +: SAMPLE_W];
  assign dout = shiftReg[SHIFT_W-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
    end else if (strobes.clearOut) begin
      shiftReg <= '0;
    end else if (strobes.frameStart) begin
      shiftReg <= {{DATA_POS{1'b0}}, selSample};
    end else if (strobes.shiftOut) begin
      shiftReg <= {shiftReg[SHIFT_W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrShift    <= '0;
      capturedAddr <= '0;
      frameDone    <= 1'b0;
    end else begin
      frameDone <= strobes.commit;
      if (strobes.addrBit) addrShift <= ADDR_W'({addrShift, dinQ});
      if (strobes.commit) capturedAddr <= addrShift;
    end
  end

endmodule

// File: rtl/adc_serial_responder.sv
module adc_serial_responder
  import adc_resp_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int SAMPLE_W = 12,
  parameter int ADDR_POS = 2,
  parameter int DATA_POS = 4,
  parameter int SYNC_STAGES = 2,
  localparam int ADDR_W = $clog2(NUM_CH),
  localparam int FRAME_LEN = DATA_POS + SAMPLE_W
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       csN,
  input  logic                       sclk,
  input  logic                       din,
  input  logic [NUM_CH*SAMPLE_W-1:0] chanData,
  output logic                       dout,
  output logic                       frameDone,
  output logic [ADDR_W-1:0]          capturedAddr
);

  logic csQ, sclkQ, dinQ, csPrev;
  ctrlStrobes_t strobes;

  adc_resp_sync #(
    .WIDTH(3),
    .STAGES(SYNC_STAGES),
    .IDLE_VAL(3'b110)
  ) u_sync (
    .clk(clk),
    .rstN(rstN),
    .rawIn({csN, sclk, din}),
    .syncOut({csQ, sclkQ, dinQ})
  );

  adc_resp_ctrl #(
    .FRAME_LEN(FRAME_LEN),
    .ADDR_POS(ADDR_POS),
    .ADDR_W(ADDR_W)
  ) u_ctrl (
    .clk(clk),
    .rstN(rstN),
    .csQ(csQ),
    .sclkQ(sclkQ),
    .csPrev(csPrev),
    .strobes(strobes)
  );

  adc_resp_datapath #(
    .NUM_CH(NUM_CH),
    .SAMPLE_W(SAMPLE_W),
    .DATA_POS(DATA_POS),
    .ADDR_W(ADDR_W)
  ) u_dp (
    .clk(clk),
    .rstN(rstN),
    .strobes(strobes),
    .dinQ(dinQ),
    .chanData(chanData),
    .dout(dout),
    .frameDone(frameDone),
    .capturedAddr(capturedAddr)
  );

endmodule

// File: rtl/adc_resp_checker.sv
module adc_resp_checker #(
  parameter int ADDR_W = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic              frameDone,
  input logic              dout,
  input logic              csQ,
  input logic              csPrev,
  input logic [ADDR_W-1:0] capturedAddr
);

  p_done_single_r6: assert property (@(posedge clk) disable iff (!rstN)
    frameDone |=> !frameDone);

  p_addr_moves_on_done_r5: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(capturedAddr) |-> frameDone);

  p_quiet_when_deselected_r8: assert property (@(posedge clk) disable iff (!rstN)
    (csQ && csPrev) |-> !dout);

  p_done_inside_frame_r7: assert property (@(posedge clk) disable iff (!rstN)
    frameDone |-> !csPrev);

endmodule

bind adc_serial_responder adc_resp_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk),
  .rstN(rstN),
  .frameDone(frameDone),
  .dout(dout),
  .csQ(csQ),
  .csPrev(csPrev),
  .capturedAddr(capturedAddr)
);

// File: tb/sim_adc_serial_responder.sv
module sim_adc_serial_responder;

  localparam int CLK_PERIOD = 10;
  localparam int HALF = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic csN = 1'b1;
  logic sclk = 1'b1;
  logic din = 1'b0;
  logic [11:0] chanVals [8];
  logic [95:0] chanData;
  logic dout, frameDone;
  logic [2:0] capturedAddr;

  int total = 0;
  int bad = 0;
  int doneCnt = 0;
  bit finished = 1'b0;
  logic [2:0] prevAddr;

  always #(CLK_PERIOD/2) clk = ~clk;

  always_comb begin
    for (int i = 0; i < 8; i++) chanData[i*12 +: 12] = chanVals[i];
  end

  always @(negedge clk) if (rstN && frameDone) doneCnt++;

  adc_serial_responder u0 (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .din(din),
    .chanData(chanData), .dout(dout), .frameDone(frameDone),
    .capturedAddr(capturedAddr)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic expBit(input logic [11:0] s, input int p);
    return (p < 4) ? 1'b0 : s[15-p];
  endfunction

  // Runs one frame with 'rises' rising edges; 16 is a full frame.
  task automatic runFrame(input logic [2:0] addr, input int rises,
                          input logic [11:0] expS, input bit mutate);
    csN = 1'b0;
    waitClk(HALF);
    for (int p = 0; p < rises; p++) begin
      sclk = 1'b0;
      din = (p >= 2 && p <= 4) ? addr[4-p] : 1'($urandom % 2);
      waitClk(HALF);
      check(dout == expBit(expS, p),
            (mutate && p > 6) ? "R10" : ((p < 4) ? "R3" : "R4"),
            int'(dout), int'(expBit(expS, p)));
      if (mutate && p == 6)
        for (int c = 0; c < 8; c++) chanVals[c] = 12'($urandom);
      sclk = 1'b1;
      waitClk(HALF);
    end
    csN = 1'b1;
    waitClk(HALF);
    check(dout == 1'b0, "R8", int'(dout), 0);
  endtask

  task automatic fullFrame(input logic [2:0] addr, input bit mutate);
    int d0;
    d0 = doneCnt;
    runFrame(addr, 16, chanVals[prevAddr], mutate);
    check(doneCnt == d0 + 1, "R6", doneCnt - d0, 1);
    check(capturedAddr == addr, "R2", int'(capturedAddr), int'(addr));
    prevAddr = addr;
  endtask

  initial begin
    void'($urandom(32'd2024));
    for (int c = 0; c < 8; c++) chanVals[c] = 12'($urandom);
    chanVals[0] = 12'hFFF;
    prevAddr = 3'd0;
    waitClk(3);
    rstN = 1'b1;
    waitClk(4);
    // R1: reset state
    check(dout == 1'b0, "R1", int'(dout), 0);
    check(frameDone == 1'b0, "R1", int'(frameDone), 0);
    check(capturedAddr == 3'd0, "R1", int'(capturedAddr), 0);

    // R5: first frame after reset reports channel 0 (all ones)
    fullFrame(3'd5, 1'b0);
    chanVals[5] = 12'h000;
    fullFrame(3'd2, 1'b0);   // returns channel 5 = 0
    chanVals[2] = 12'hA5A;
    fullFrame(3'd7, 1'b0);   // returns channel 2

    // R7: aborted frames, short and past the address field
    begin
      int d0;
      d0 = doneCnt;
      runFrame(3'd1, 3, chanVals[prevAddr], 1'b0);
      check(doneCnt == d0, "R7", doneCnt - d0, 0);
      check(capturedAddr == prevAddr, "R7", int'(capturedAddr), int'(prevAddr));
      runFrame(3'd4, 11, chanVals[prevAddr], 1'b0);
      check(doneCnt == d0, "R7", doneCnt - d0, 0);
      check(capturedAddr == prevAddr, "R7", int'(capturedAddr), int'(prevAddr));
    end
    fullFrame(3'd3, 1'b0);   // R5: still reports channel 7 after aborts

    // R9: serial clock toggling while deselected
    begin
      int d0;
      d0 = doneCnt;
      for (int k = 0; k < 20; k++) begin
        sclk = 1'b0; din = 1'($urandom % 2); waitClk(HALF);
        check(dout == 1'b0, "R9", int'(dout), 0);
        sclk = 1'b1; waitClk(HALF);
      end
      check(doneCnt == d0, "R9", doneCnt - d0, 0);
      check(capturedAddr == prevAddr, "R9", int'(capturedAddr), int'(prevAddr));
    end

    // R10: sample frozen at frame start
    fullFrame(3'd6, 1'b1);
    fullFrame(3'd0, 1'b1);

    // Random frames, some aborted
    for (int n = 0; n < 24; n++) begin
      logic [2:0] a;
      a = 3'($urandom);
      if (($urandom % 5) == 0) begin
        int d0;
        d0 = doneCnt;
        runFrame(a, 1 + int'($urandom % 15), chanVals[prevAddr], 1'b0);
        check(doneCnt == d0, "R7", doneCnt - d0, 0);
        check(capturedAddr == prevAddr, "R7", int'(capturedAddr), int'(prevAddr));
      end else begin
        for (int c = 0; c < 8; c++) chanVals[c] = 12'($urandom);
        fullFrame(a, 1'b0);
      end
    end

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL R6 watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule